// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

This block is a real-time clock peripheral that sits on a simple 32-bit register port. A slow reference clock enters as a level, passes through a two-stage synchronizer and an edge detector, and a prescaler turns its rising edges into a one-per-second step. Each step advances a 32-bit seconds count while the run bit is set. The same step raises a per-second event flag. It also raises an alarm event flag when the count lands on the programmed alarm value. One level interrupt output combines the two flags, each under its own enable.

There is no streaming interface. Reads are combinational from `reg_addr`. Writes are single-cycle strobes, and back-pressure is carried by the write-ready bit of the control register. After every accepted write that bit stays low for a fixed number of slow-clock rising edges. Any write presented while it is low is dropped. With the unlock variant selected, a key register must first be loaded with the magic word, and the key is spent by the next accepted write. Software therefore polls write-ready, writes the key, polls again, and then writes the target register. Software should also read the seconds register twice and accept the value only when both reads agree.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the control register reads 0x80 (write-ready high, everything else clear), and the seconds, alarm, trim and key registers read 0 with `irq` low.
- R2: The seconds register (offset 0x04) increases by one for every PRESCALE synchronized rising edges of `slow_clk` only while run (control bit 0) is set; an accepted write to it takes precedence over an increment in the same cycle.
- R3: The seconds count wraps from 0xFFFFFFFF to 0x00000000.
- R4: A write is accepted only while write-ready (control bit 7) is 1; after an accepted write that bit reads 0 until WR_BUSY_TICKS further synchronized slow-clock rising edges have passed; a dropped write changes no register.
- R5: With UNLOCK_EN set, writing 0x0000A55A to offset 0x3C sets bit 31 of that register; writes to other registers are dropped while bit 31 is 0, and bit 31 returns to 0 after one write is accepted.
- R6: The alarm flag (control bit 4) and the per-second flag (control bit 6) are cleared by writing 0 to them and kept by writing 1; write-ready (bit 7) ignores writes.
- R7: The alarm flag is set in the cycle the seconds count steps onto the value held at offset 0x08, provided alarm enable (control bit 2) and run are set.
- R8: Every increment of the seconds count sets the per-second flag.
- R9: `irq` is high exactly when (alarm flag and control bit 3) or (per-second flag and control bit 5).
- R10: The scratchpad at offset 0x34 keeps its value through reset; the trim register at 0x0C stores what is written and is cleared by reset.
- R11: Reads of any offset outside 0x00, 0x04, 0x08, 0x0C, 0x34 and 0x3C return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock level, synchronized inside |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench times writes so that they land while write-ready is low. A design that ignored the busy window would change the register, and one that reopened the window early would show ready a cycle too soon. It fires a run of seconds writes across every phase of the prescaler. If an increment won over the load, the value read back would be one too high. It clears the flags by writing 0 and keeps them by writing 1, and a design that inverted that sense would either drop a pending event or make it impossible to clear. It also checks the wrap at the top of the count, that the alarm fires on the step onto the value, that the unlock key is spent after one write, and that the scratchpad survives reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // register offsets (byte addresses)
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_SEC  = 8'h04;
  localparam logic [7:0] A_ALRM = 8'h08;
  localparam logic [7:0] A_TRIM = 8'h0C;
  localparam logic [7:0] A_SCR  = 8'h34;
  localparam logic [7:0] A_KEY  = 8'h3C;

  // control register bit positions
  localparam int B_RUN     = 0;
  localparam int B_AL_ON   = 2;
  localparam int B_AL_IE   = 3;
  localparam int B_AL_FLAG = 4;
  localparam int B_HZ_IE   = 5;
  localparam int B_HZ_FLAG = 6;
  localparam int B_WRDY    = 7;

  localparam logic [31:0] KEY_MAGIC = 32'h0000_A55A;
endpackage

// File: rtl/rtc_slow_tick.sv
module rtc_slow_tick #(
  parameter int DIV         = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic slow_rise,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  // sh[0] is the first synchronizer stage, sh[SYNC_STAGES] the edge-detect delay
  logic [SYNC_STAGES:0] sh;
  logic [CW-1:0]        pre;
  logic                 last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], slow_clk};
  end

  assign slow_rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign last      = (pre == CW'(DIV - 1));
  assign sec_tick  = slow_rise & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre <= '0;
    else if (slow_rise) pre <= last ? '0 : pre + 1'b1;
  end
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int DATA_W        = 32,
  parameter int BUSY_TICKS    = 2,
  parameter bit UNLOCK_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_rise,
  input  logic              wr_req,
  input  logic              key_sel,
  input  logic              mapped,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_ready,
  output logic              wr_accept,
  output logic              key_open
);
  localparam int BW = $clog2(BUSY_TICKS + 1);

  logic [BW-1:0] busy;
  logic          permit;

  assign wr_ready  = (busy == '0);
  assign wr_accept = wr_req & ~key_sel & mapped & wr_ready & permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        busy <= '0;
    else if (wr_accept)                busy <= BW'(BUSY_TICKS);
    else if (slow_rise && busy != '0)  busy <= busy - 1'b1;
  end

  generate
    if (UNLOCK_EN) begin : g_key
      logic key_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          key_q <= 1'b0;
        else if (wr_req && key_sel && wdata == DATA_W'(rtc_pkg::KEY_MAGIC)) key_q <= 1'b1;
        else if (wr_accept)                                  key_q <= 1'b0;
      end
      assign permit   = key_q;
      assign key_open = key_q;

      AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !key_open); // R5
    end else begin : g_nokey
      logic unused_w;
      assign unused_w = ^wdata;
      assign permit   = 1'b1;
      assign key_open = 1'b0;
    end
  endgenerate

  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_ready); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !slow_rise) |=> !wr_ready); // R4
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              run,
  input  logic              al_on,
  input  logic [DATA_W-1:0] alarm_val,
  input  logic              sec_load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              ctrl_wr,
  input  logic              keep_al,
  input  logic              keep_hz,
  output logic [DATA_W-1:0] seconds,
  output logic              al_flag,
  output logic              hz_flag
);
  logic              step;
  logic [DATA_W-1:0] nxt;

  assign step = sec_tick & run;
  assign nxt  = seconds + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seconds <= '0;
    else if (sec_load) seconds <= load_val;
    else if (step)     seconds <= nxt;
  end

  // event set has priority over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hz_flag <= 1'b0;
    else if (step)                hz_flag <= 1'b1;
    else if (ctrl_wr && !keep_hz) hz_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  al_flag <= 1'b0;
    else if (step && al_on && nxt == alarm_val)  al_flag <= 1'b1;
    else if (ctrl_wr && !keep_al)                al_flag <= 1'b0;
  end

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_load && !step) |=> $stable(seconds)); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_load && step) |=> seconds == $past(seconds) + 1'b1); // R3
  AST_HZ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> hz_flag); // R8
  AST_HZ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_flag && !ctrl_wr) |=> hz_flag); // R6
  AST_AL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (al_flag && !ctrl_wr) |=> al_flag); // R6
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int PRESCALE      = 32768,
  parameter int WR_BUSY_TICKS = 2,
  parameter bit UNLOCK_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic slow_rise, sec_tick;
  logic wr_ready, wr_accept, key_open;
  logic sel_ctrl, sel_sec, sel_alrm, sel_trim, sel_scr, sel_key, mapped;
  logic run_q, al_on_q, al_ie_q, hz_ie_q;
  logic al_flag, hz_flag;
  logic [DATA_W-1:0] seconds, alarm_q, trim_q, scr_q;

  assign sel_ctrl = (reg_addr == ADDR_W'(A_CTRL));
  assign sel_sec  = (reg_addr == ADDR_W'(A_SEC));
  assign sel_alrm = (reg_addr == ADDR_W'(A_ALRM));
  assign sel_trim = (reg_addr == ADDR_W'(A_TRIM));
  assign sel_scr  = (reg_addr == ADDR_W'(A_SCR));
  assign sel_key  = (reg_addr == ADDR_W'(A_KEY));
  assign mapped   = sel_ctrl | sel_sec | sel_alrm | sel_trim | sel_scr;

  rtc_slow_tick #(.DIV(PRESCALE), .SYNC_STAGES(2)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_clk  (slow_clk),
    .slow_rise (slow_rise),
    .sec_tick  (sec_tick)
  );

  rtc_wr_gate #(.DATA_W(DATA_W), .BUSY_TICKS(WR_BUSY_TICKS), .UNLOCK_EN(UNLOCK_EN)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_rise (slow_rise),
    .wr_req    (reg_wr),
    .key_sel   (sel_key),
    .mapped    (mapped),
    .wdata     (reg_wdata),
    .wr_ready  (wr_ready),
    .wr_accept (wr_accept),
    .key_open  (key_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      al_on_q <= 1'b0;
      al_ie_q <= 1'b0;
      hz_ie_q <= 1'b0;
    end else if (wr_accept && sel_ctrl) begin
      run_q   <= reg_wdata[B_RUN];
      al_on_q <= reg_wdata[B_AL_ON];
      al_ie_q <= reg_wdata[B_AL_IE];
      hz_ie_q <= reg_wdata[B_HZ_IE];
    end
  end

  rtc_time_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .run       (run_q),
    .al_on     (al_on_q),
    .alarm_val (alarm_q),
    .sec_load  (wr_accept & sel_sec),
    .load_val  (reg_wdata),
    .ctrl_wr   (wr_accept & sel_ctrl),
    .keep_al   (reg_wdata[B_AL_FLAG]),
    .keep_hz   (reg_wdata[B_HZ_FLAG]),
    .seconds   (seconds),
    .al_flag   (al_flag),
    .hz_flag   (hz_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      trim_q  <= '0;
    end else if (wr_accept) begin
      if (sel_alrm) alarm_q <= reg_wdata;
      if (sel_trim) trim_q  <= reg_wdata;
    end
  end

  // scratchpad deliberately has no reset so it survives a warm reset
  always_ff @(posedge clk) begin
    if (wr_accept && sel_scr) scr_q <= reg_wdata;
  end

  assign irq = (al_flag & al_ie_q) | (hz_flag & hz_ie_q);

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata[B_RUN]     = run_q;
      reg_rdata[B_AL_ON]   = al_on_q;
      reg_rdata[B_AL_IE]   = al_ie_q;
      reg_rdata[B_AL_FLAG] = al_flag;
      reg_rdata[B_HZ_IE]   = hz_ie_q;
      reg_rdata[B_HZ_FLAG] = hz_flag;
      reg_rdata[B_WRDY]    = wr_ready;
    end else if (sel_sec)  reg_rdata = seconds;
    else if (sel_alrm)     reg_rdata = alarm_q;
    else if (sel_trim)     reg_rdata = trim_q;
    else if (sel_scr)      reg_rdata = scr_q;
    else if (sel_key)      reg_rdata[DATA_W-1] = key_open;
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (al_flag || hz_flag)); // R9
  AST_REJECT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_ready && sel_trim) |=> $stable(trim_q)); // R4
endmodule

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int BUSY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  rtc_sec_alarm #(.ADDR_W(8), .DATA_W(32), .PRESCALE(DIV), .WR_BUSY_TICKS(BUSY), .UNLOCK_EN(1'b1)) i_rtc_sec_alarm (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow clock: toggles every 3 bus clocks
  int scnt = 0;
  always @(posedge clk) begin
    #1;
    if (scnt == 2) begin scnt = 0; slow_clk = ~slow_clk; end
    else scnt++;
  end

  // ---------------- behavioural reference model ----------------
  bit m_s1, m_s2, m_s3, m_wen, m_run, m_ae, m_aie, m_af, m_hie, m_hf;
  int unsigned m_pre, m_busy;
  logic [31:0] m_sec, m_alr, m_trim, m_scr;

  function automatic bit is_mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h34;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      8'h00: begin
        v[0] = m_run; v[2] = m_ae; v[3] = m_aie; v[4] = m_af;
        v[5] = m_hie; v[6] = m_hf; v[7] = (m_busy == 0);
      end
      8'h04: v = m_sec;
      8'h08: v = m_alr;
      8'h0C: v = m_trim;
      8'h34: v = m_scr;
      8'h3C: v[31] = m_wen;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R6";
      8'h04: return "R2";
      8'h08: return "R7";
      8'h0C: return "R10";
      8'h34: return "R10";
      8'h3C: return "R5";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, tick, step, acc, keyw;
    logic [31:0] nxt;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_busy = 0; m_wen = 0;
      m_run = 0; m_ae = 0; m_aie = 0; m_af = 0; m_hie = 0; m_hf = 0;
      m_sec = 0; m_alr = 0; m_trim = 0;
    end else begin
      rise = m_s2 && !m_s3;
      tick = rise && (m_pre == DIV - 1);
      step = tick && m_run;
      nxt  = m_sec + 1;
      keyw = reg_wr && reg_addr == 8'h3C;
      acc  = reg_wr && !keyw && is_mapped(reg_addr) && (m_busy == 0) && m_wen;
      // flags: clear by write 0, then event set wins
      if (acc && reg_addr == 8'h00) begin
        m_hf = m_hf && reg_wdata[6];
        m_af = m_af && reg_wdata[4];
      end
      if (step) m_hf = 1;
      if (step && m_ae && nxt == m_alr) m_af = 1;
      if (step) m_sec = nxt;
      if (acc) begin
        case (reg_addr)
          8'h00: begin m_run = reg_wdata[0]; m_ae = reg_wdata[2]; m_aie = reg_wdata[3]; m_hie = reg_wdata[5]; end
          8'h04: m_sec = reg_wdata;
          8'h08: m_alr = reg_wdata;
          8'h0C: m_trim = reg_wdata;
          8'h34: m_scr = reg_wdata;
          default: ;
        endcase
      end
      if (keyw && reg_wdata == 32'h0000A55A) m_wen = 1;
      else if (acc) m_wen = 0;
      if (acc) m_busy = BUSY;
      else if (rise && m_busy > 0) m_busy--;
      if (rise) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = slow_clk;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
      chk("R9", {31'b0, irq}, {31'b0, (m_af & m_aie) | (m_hf & m_hie)});
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1; reg_wr = 0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(8'h00, v);
      if (v[7]) return;
    end
    chk("R4", 32'h0, 32'h80);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wait_ready();
    wr_raw(8'h3C, 32'h0000A55A);
    wr_raw(a, d);
  endtask

  task automatic wait_irq(input string tag);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    chk(tag, {31'b0, irq}, 32'h1);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
  endtask

  initial begin
    logic [31:0] v, s;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;

    // R1: reset state
    rd_chk("R1", 8'h00, 32'h80);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h08, 32'h0);
    rd_chk("R1", 8'h3C, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    // R11: unmapped read and write
    rd_chk("R11", 8'h10, 32'h0);

    // R5: write without key is dropped
    wr_raw(8'h04, 32'd77);
    rd_chk("R5", 8'h04, 32'h0);
    rd_chk("R5", 8'h00, 32'h80);
    wr_raw(8'h3C, 32'h0000A55A);
    rd_chk("R5", 8'h3C, 32'h8000_0000);
    wr_raw(8'h04, 32'd100);
    rd_chk("R4", 8'h00, 32'h00);          // busy right after accept
    rd_chk("R5", 8'h3C, 32'h0);           // key spent
    // R4: write while busy is dropped
    wr_raw(8'h3C, 32'h0000A55A);
    wr_raw(8'h04, 32'd5);
    wait_ready();
    rd_chk("R4", 8'h04, 32'd100);
    // R11: unmapped write has no effect and leaves key open
    wr_raw(8'h20, 32'hFFFF_FFFF);
    rd_chk("R11", 8'h20, 32'h0);
    rd_chk("R11", 8'h3C, 32'h8000_0000);
    // R2: no counting while run is clear
    repeat (60) @(posedge clk);
    rd_chk("R2", 8'h04, 32'd100);

    // R8/R9: per-second event with enable
    wr_reg(8'h00, 32'h21);
    wait_irq("R8");
    rd(8'h00, v);
    chk("R8", {31'b0, v[6]}, 32'h1);
    // R9: mask per-second interrupt, flag still sets
    wr_reg(8'h00, 32'h01);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R9", {31'b0, irq}, 32'h0);
    rd(8'h00, v);
    chk("R9", {31'b0, v[6]}, 32'h1);

    // R2: seconds writes across all prescaler phases
    for (int k = 0; k < 30; k++) begin
      wr_reg(8'h04, 32'd1000 + k);
      rd(8'h04, v);
      chk("R2", {31'b0, (v == 32'd1000 + k) || (v == 32'd1001 + k)}, 32'h1);
    end

    // R7: alarm
    rd(8'h04, s);
    wr_reg(8'h08, s + 6);
    wr_reg(8'h00, 32'h0D);
    wait_irq("R7");
    rd_chk("R7", 8'h04, s + 6);
    rd(8'h00, v);
    chk("R7", {31'b0, v[4]}, 32'h1);
    // R6: writing 1 keeps the alarm flag, writing 0 clears it
    wr_reg(8'h00, 32'h1D);
    wait_ready();
    rd(8'h00, v);
    chk("R6", {31'b0, v[4]}, 32'h1);
    wr_reg(8'h00, 32'h0D);
    rd(8'h00, v);
    chk("R6", {31'b0, v[4]}, 32'h0);
    chk("R9", {31'b0, irq}, 32'h0);
    // R6: bit 7 ignores writes (write 0 to it, still ready once idle)
    wait_ready();
    rd(8'h00, v);
    chk("R6", {31'b0, v[7]}, 32'h1);

    // R3: wrap
    wr_reg(8'h04, 32'hFFFF_FFFF);
    for (int i = 0; i < 100; i++) begin
      rd(8'h04, v);
      if (v != 32'hFFFF_FFFF) break;
    end
    chk("R3", v, 32'h0);

    // R10: scratchpad survives reset, trim does not
    wr_reg(8'h34, 32'h1234_5678);
    wr_reg(8'h0C, 32'h0000_BEEF);
    rd_chk("R10", 8'h0C, 32'h0000_BEEF);
    do_reset();
    rd_chk("R10", 8'h34, 32'h1234_5678);
    rd_chk("R1", 8'h0C, 32'h0);
    rd_chk("R1", 8'h00, 32'h80);
    rd_chk("R1", 8'h04, 32'h0);

    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule